// File: doc/BRIEF.md
# Vectored Edge/Level Interrupt Router

This block collects up to `NUM_SRC` interrupt request inputs and routes each one onto one of `NUM_OUT` parent interrupt lines. Each source is configured as level-sensitive or edge-sensitive. The router keeps three per-source bit vectors:

- a pending vector;
- an in-service vector;
- a last-seen input level.

A mask register keeps a source from being delivered. Every source owns one byte in a vector table, and that byte picks the parent line the source drives.

Each delivery step serves only the lowest-numbered eligible source. An input rising, an input falling, a mask write and a clear write each start such a step, and each step sets or clears a single parent line. Edge sources stay pending until software clears them through the clear register. A mask write evaluates again only the bits whose mask value changed.

Software reaches the registers through a simple request port. `req_ready_o` is always high, so a request is taken in every cycle that `req_valid_i` is high. A read returns its data on `rsp_rdata_o` with `rsp_valid_o` high exactly one cycle later. The response path has no back-pressure: the requester must take the data in that cycle.

Top module: `irq_vector_router`

## Requirements
- R1: After reset the mask register reads all ones. Edge select, message enable, polarity, both tables, pending and in-service all read zero. `irq_out_o` is zero, and the identity word (0x000) reads `ID_VALUE`.
- R2: Size code 0/1/2/3 selects a 1/2/4/8-byte access. The word is `req_addr_i[ADDR_W-1:3]` and the byte offset is `req_addr_i[2:0]`. A read returns the word shifted right by 8 × offset and truncated to the access size. A write replaces only the addressed bytes and leaves the other bytes unchanged.
- R3: For a level source (edge-select bit 0 at 0x040), pending follows the input.
  - If the source is unmasked, a rising input sets its in-service bit and raises the line its vector selects after the next clock edge.
  - A falling input clears the in-service bit and lowers that line.
- R4: For an edge source (edge-select bit 1), pending is set only when the input goes from low to high. A falling input never clears pending, so a pulse taken while the source is masked is still delivered once the source is unmasked.
- R5: All rising inputs seen in one cycle form one delivery step, and all falling inputs form another. Only the lowest-numbered eligible source in each step changes a parent line.
- R6: A write to the clear word (0x060) acts only on bits that select edge mode. For those bits it:
  - removes their pending state;
  - lowers the line of the lowest-numbered one that is in service;
  - clears all of their in-service bits.
  Bits that select level mode are unaffected.
- R7: In the mask word (0x020), a 1 masks the source. After a mask write:
  - bits that went from masked to unmasked get the rising step, so a pending source goes in service and its line rises;
  - bits that went from unmasked to masked get the falling step, which acts only on bits that are in service and no longer pending.
- R8: The status word (0x100) is read-only and reads in-service AND NOT mask.
- R9: The two auto-control words (0x0A0 and 0x0C0) and every unmapped address read zero and ignore writes. The identity word ignores writes.
- R10: The vector table starts at 0x200 and the route table at 0x300. Each holds one byte per source, with source i in byte i%8 of word i/8. The polarity word (0x0E0) and the message-enable word (0x080) are stored and read back, but have no effect on delivery.
- R11: When an input change and a register write arrive in the same cycle, the input change is applied first. An edge rising in the same cycle as a clear of that bit therefore leaves the source not pending and its line low.
- R12: `req_ready_o` is always high. `rsp_valid_o` is high exactly one cycle after an accepted read and low otherwise. The read data reflects the state before that cycle's updates.
- R13: `irq_out_o` changes only in a cycle that has an input change or a register write. At most four lines change in one cycle: two from inputs and two from a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_in_i | input | NUM_SRC | Interrupt request levels, sampled every clock |
| irq_out_o | output | NUM_OUT | Parent interrupt lines |
| req_valid_i | input | 1 | Register request present |
| req_ready_o | output | 1 | Request accepted (always high) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | 2 | Access size code |
| req_wdata_i | input | 64 | Write data, right-aligned |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 64 | Read data, right-aligned |

## Verification
The bench accounts for the following delays:

- Every input change and every register write shows up on `irq_out_o`, and in later status reads, after exactly one rising clock edge.
- Read data and `rsp_valid_o` appear one edge after the request.

The bench therefore drives each stimulus at a falling edge and samples at the next falling edge, which comes after exactly one rising edge. The same-cycle ordering case drives an input change and a clear write at the same falling edge.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
package irq_router_pkg;

  typedef enum logic [1:0] {
    SZ_1B = 2'd0,
    SZ_2B = 2'd1,
    SZ_4B = 2'd2,
    SZ_8B = 2'd3
  } acc_size_e;

  // Word indices (byte address >> 3).
  localparam int W_IDENT  = 'h000;
  localparam int W_MASK   = 'h004;
  localparam int W_EDGE   = 'h008;
  localparam int W_CLEAR  = 'h00C;
  localparam int W_MSGEN  = 'h010;
  localparam int W_AUTO0  = 'h014;
  localparam int W_AUTO1  = 'h018;
  localparam int W_POL    = 'h01C;
  localparam int W_STATUS = 'h020;
  localparam int W_VEC    = 'h040;
  localparam int W_ROUTE  = 'h060;

  function automatic logic [7:0] size_byte_mask(acc_size_e sz);
    case (sz)
      SZ_1B:   return 8'h01;
      SZ_2B:   return 8'h03;
      SZ_4B:   return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [63:0] bytes_to_bits(logic [7:0] bm);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[b*8 +: 8] = {8{bm[b]}};
    return r;
  endfunction

  function automatic logic [63:0] merge_word(logic [63:0] old, logic [63:0] wdata,
                                             acc_size_e sz, logic [2:0] off);
    logic [63:0] lane;
    logic [63:0] shifted;
    lane    = bytes_to_bits(size_byte_mask(sz) << off);
    shifted = (wdata & bytes_to_bits(size_byte_mask(sz))) << {off, 3'b000};
    return (old & ~lane) | (shifted & lane);
  endfunction

  function automatic logic [63:0] slice_word(logic [63:0] val, acc_size_e sz, logic [2:0] off);
    return (val >> {off, 3'b000}) & bytes_to_bits(size_byte_mask(sz));
  endfunction

endpackage

// File: rtl/irq_lowest_pick.sv
`timescale 1ns/1ps
module irq_lowest_pick #(
  parameter int W  = 64,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  cand_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  assign found_o = |cand_i;

  // Scan from the top so the lowest set bit is the last one assigned.
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (cand_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irq_level_track.sv
`timescale 1ns/1ps
module irq_level_track #(
  parameter int NUM_SRC = 64
) (
  input  logic [NUM_SRC-1:0] lvl_i,
  input  logic [NUM_SRC-1:0] last_i,
  input  logic [NUM_SRC-1:0] edge_mode_i,
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] rise_o,
  output logic [NUM_SRC-1:0] fall_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign rise_o[g] = lvl_i[g] & ~last_i[g];
    assign fall_o[g] = ~lvl_i[g] & last_i[g];
    // Edge: latch on rising edge, hold on falling. Level: follow the input.
    assign pend_o[g] = edge_mode_i[g] ? (pend_i[g] | rise_o[g]) : lvl_i[g];
  end
endmodule

// File: rtl/irq_cfg_regs.sv
`timescale 1ns/1ps
module irq_cfg_regs
  import irq_router_pkg::*;
#(
  parameter int          NUM_SRC  = 64,
  parameter int          ADDR_W   = 12,
  parameter logic [63:0] ID_VALUE = 64'h0040_0100_5256_4952
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic                 req_write_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [1:0]           req_size_i,
  input  logic [63:0]          req_wdata_i,
  input  logic [NUM_SRC-1:0]   isr_i,
  output logic [NUM_SRC-1:0]   mask_o,
  output logic [NUM_SRC-1:0]   mask_next_o,
  output logic                 mask_wr_o,
  output logic [NUM_SRC-1:0]   edge_o,
  output logic [NUM_SRC-1:0]   clr_o,
  output logic [NUM_SRC*8-1:0] vec_o,
  output logic                 rsp_valid_o,
  output logic [63:0]          rsp_rdata_o
);
  localparam int TBL_WORDS = NUM_SRC / 8;
  localparam int TBL_BITS  = NUM_SRC * 8;

  logic [NUM_SRC-1:0]  mask_q, edge_q, msgen_q, pol_q;
  logic [NUM_SRC-1:0]  mask_d, edge_d, msgen_d, pol_d;
  logic [TBL_BITS-1:0] vec_q, route_q, vec_d, route_d;
  logic [63:0]         rd_word;

  acc_size_e       sz;
  logic [2:0]      off;
  int              widx;
  logic            wr, rd;

  assign sz   = acc_size_e'(req_size_i);
  assign off  = req_addr_i[2:0];
  assign widx = int'(req_addr_i[ADDR_W-1:3]);
  assign wr   = req_valid_i & req_write_i;
  assign rd   = req_valid_i & ~req_write_i;

  always_comb begin
    mask_d  = mask_q;
    edge_d  = edge_q;
    msgen_d = msgen_q;
    pol_d   = pol_q;
    vec_d   = vec_q;
    route_d = route_q;
    clr_o   = '0;
    if (wr) begin
      if (widx == W_MASK)  mask_d  = NUM_SRC'(merge_word(64'(mask_q), req_wdata_i, sz, off));
      if (widx == W_EDGE)  edge_d  = NUM_SRC'(merge_word(64'(edge_q), req_wdata_i, sz, off));
      if (widx == W_MSGEN) msgen_d = NUM_SRC'(merge_word(64'(msgen_q), req_wdata_i, sz, off));
      if (widx == W_POL)   pol_d   = NUM_SRC'(merge_word(64'(pol_q), req_wdata_i, sz, off));
      if (widx == W_CLEAR) clr_o   = NUM_SRC'(merge_word(64'h0, req_wdata_i, sz, off));
      for (int w = 0; w < TBL_WORDS; w++) begin
        if (widx == W_VEC + w)
          vec_d[w*64 +: 64] = merge_word(vec_q[w*64 +: 64], req_wdata_i, sz, off);
        if (widx == W_ROUTE + w)
          route_d[w*64 +: 64] = merge_word(route_q[w*64 +: 64], req_wdata_i, sz, off);
      end
    end
  end

  always_comb begin
    rd_word = '0;
    case (widx)
      W_IDENT:  rd_word = ID_VALUE;
      W_MASK:   rd_word = 64'(mask_q);
      W_EDGE:   rd_word = 64'(edge_q);
      W_MSGEN:  rd_word = 64'(msgen_q);
      W_POL:    rd_word = 64'(pol_q);
      W_STATUS: rd_word = 64'(isr_i & ~mask_q);
      default:  rd_word = '0;
    endcase
    for (int w = 0; w < TBL_WORDS; w++) begin
      if (widx == W_VEC + w)   rd_word = vec_q[w*64 +: 64];
      if (widx == W_ROUTE + w) rd_word = route_q[w*64 +: 64];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q      <= '1;
      edge_q      <= '0;
      msgen_q     <= '0;
      pol_q       <= '0;
      vec_q       <= '0;
      route_q     <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      mask_q      <= mask_d;
      edge_q      <= edge_d;
      msgen_q     <= msgen_d;
      pol_q       <= pol_d;
      vec_q       <= vec_d;
      route_q     <= route_d;
      rsp_valid_o <= rd;
      rsp_rdata_o <= rd ? slice_word(rd_word, sz, off) : '0;
    end
  end

  assign mask_o      = mask_q;
  assign mask_next_o = mask_d;
  assign mask_wr_o   = wr && (widx == W_MASK);
  assign edge_o      = edge_q;
  assign vec_o       = vec_q;
endmodule

// File: rtl/irq_vector_router.sv
`timescale 1ns/1ps
module irq_vector_router #(
  parameter int          NUM_SRC  = 64,
  parameter int          NUM_OUT  = 256,
  parameter int          ADDR_W   = 12,
  parameter logic [63:0] ID_VALUE = 64'h0040_0100_5256_4952
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_in_i,
  output logic [NUM_OUT-1:0] irq_out_o,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [1:0]         req_size_i,
  input  logic [63:0]        req_wdata_i,
  output logic               rsp_valid_o,
  output logic [63:0]        rsp_rdata_o
);
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int OW = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;
  localparam logic [NUM_SRC-1:0] ONE = NUM_SRC'(1);

  logic [NUM_SRC-1:0]   isr_q, irr_q, last_q;
  logic [NUM_OUT-1:0]   out_q, out_d;
  logic [NUM_SRC-1:0]   mask_q, mask_nx, edge_q, clr_bits;
  logic                 mask_wr;
  logic [NUM_SRC*8-1:0] vec_q;

  irq_cfg_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)) u_regs (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_addr_i, .req_size_i, .req_wdata_i,
    .isr_i(isr_q), .mask_o(mask_q), .mask_next_o(mask_nx), .mask_wr_o(mask_wr),
    .edge_o(edge_q), .clr_o(clr_bits), .vec_o(vec_q),
    .rsp_valid_o, .rsp_rdata_o
  );

  // Input stage
  logic [NUM_SRC-1:0] irr_a, rise, fall;
  irq_level_track #(.NUM_SRC(NUM_SRC)) u_track (
    .lvl_i(irq_in_i), .last_i(last_q), .edge_mode_i(edge_q), .pend_i(irr_q),
    .pend_o(irr_a), .rise_o(rise), .fall_o(fall)
  );

  logic [NUM_SRC-1:0] c1, c2, c3, c4;
  logic [NUM_SRC-1:0] isr_a, isr_b, isr_c, isr_d;
  logic [NUM_SRC-1:0] up, down, cm, irr_c;
  logic               f1, f2, f3, f4;
  logic [IW-1:0]      i1, i2, i3, i4;

  assign c1 = rise & irr_a & ~mask_q;
  irq_lowest_pick #(.W(NUM_SRC)) u_pick_in_rise (.cand_i(c1), .found_o(f1), .idx_o(i1));
  assign isr_a = isr_q | (f1 ? (ONE << i1) : '0);

  assign c2 = fall & isr_a & ~irr_a;
  irq_lowest_pick #(.W(NUM_SRC)) u_pick_in_fall (.cand_i(c2), .found_o(f2), .idx_o(i2));
  assign isr_b = isr_a & ~(f2 ? (ONE << i2) : '0);

  // Register-write stage, applied after the inputs
  assign up    = mask_wr ? (mask_q & ~mask_nx) : '0;
  assign down  = mask_wr ? (~mask_q & mask_nx) : '0;
  assign cm    = clr_bits & edge_q;
  assign irr_c = irr_a & ~cm;

  assign c3 = up & irr_c & ~mask_nx;
  irq_lowest_pick #(.W(NUM_SRC)) u_pick_wr_rise (.cand_i(c3), .found_o(f3), .idx_o(i3));
  assign isr_c = isr_b | (f3 ? (ONE << i3) : '0);

  assign c4 = (down | cm) & isr_c & ~irr_c;
  irq_lowest_pick #(.W(NUM_SRC)) u_pick_wr_fall (.cand_i(c4), .found_o(f4), .idx_o(i4));
  assign isr_d = isr_c & ~(f4 ? (ONE << i4) : '0) & ~cm;

  function automatic logic [7:0] vec_at(logic [IW-1:0] i);
    return vec_q[{i, 3'b000} +: 8];
  endfunction

  logic [7:0] v1, v2, v3, v4;
  assign v1 = vec_at(i1);
  assign v2 = vec_at(i2);
  assign v3 = vec_at(i3);
  assign v4 = vec_at(i4);

  // Four line operations, applied in order: later ones win.
  always_comb begin
    out_d = out_q;
    if (f1 && int'(v1) < NUM_OUT) out_d[OW'(v1)] = 1'b1;
    if (f2 && int'(v2) < NUM_OUT) out_d[OW'(v2)] = 1'b0;
    if (f3 && int'(v3) < NUM_OUT) out_d[OW'(v3)] = 1'b1;
    if (f4 && int'(v4) < NUM_OUT) out_d[OW'(v4)] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q  <= '0;
      irr_q  <= '0;
      last_q <= '0;
      out_q  <= '0;
    end else begin
      isr_q  <= isr_d;
      irr_q  <= irr_c;
      last_q <= irq_in_i;
      out_q  <= out_d;
    end
  end

  assign irq_out_o   = out_q;
  assign req_ready_o = 1'b1;
endmodule

// File: rtl/irq_vector_router_chk.sv
`timescale 1ns/1ps
module irq_vector_router_chk
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_OUT = 256,
  parameter int ADDR_W  = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] irq_in_i,
  input logic [NUM_OUT-1:0] irq_out_o,
  input logic               req_valid_i,
  input logic               req_write_i,
  input logic [ADDR_W-1:0]  req_addr_i,
  input logic               rsp_valid_o,
  input logic [63:0]        rsp_rdata_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  logic is_auto;
  assign is_auto = (int'(req_addr_i[ADDR_W-1:3]) == W_AUTO0) ||
                   (int'(req_addr_i[ADDR_W-1:3]) == W_AUTO1);

  a_r12_rsp_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);

  a_r12_no_rsp_otherwise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_write_i) |=> !rsp_valid_o);

  a_r9_auto_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && is_auto) |=> (rsp_rdata_o == 64'h0));

  a_r13_quiet_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !(req_valid_i && req_write_i) && (irq_in_i == $past(irq_in_i)))
      |=> $stable(irq_out_o));

  a_r13_few_changes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> ($countones(irq_out_o ^ $past(irq_out_o)) <= 4));
endmodule

bind irq_vector_router irq_vector_router_chk #(
  .NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_in_i(irq_in_i), .irq_out_o(irq_out_o),
  .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_addr_i(req_addr_i),
  .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o)
);

// File: tb/test_irq_vector_router.sv
`timescale 1ns/1ps
module test_irq_vector_router;
  localparam logic [63:0] ID = 64'h0040_0100_5256_4952;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [63:0]  irq_in = '0;
  logic [255:0] irq_out;
  logic         req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [11:0]  req_addr = '0;
  logic [1:0]   req_size = '0;
  logic [63:0]  req_wdata = '0;
  logic         rsp_valid;
  logic [63:0]  rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_vector_router i_irq_vector_router (
    .clk_i(clk), .rst_ni(rst_n), .irq_in_i(irq_in), .irq_out_o(irq_out),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_in(logic [11:0] a, logic [1:0] sz, logic [63:0] d, logic [63:0] lv);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
    irq_in = lv;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(logic [11:0] a, logic [1:0] sz, logic [63:0] d);
    wr_in(a, sz, d, irq_in);
  endtask

  task automatic rd(logic [11:0] a, logic [1:0] sz, output logic [63:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
    v = rsp_valid;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [1:0] sz, logic [63:0] exp);
    logic [63:0] d;
    logic v;
    rd(a, sz, d, v);
    check(req, d, exp);
  endtask

  task automatic set_in(logic [63:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic set_mask(logic [63:0] m);
    wr(12'h020, 2'd3, m);
  endtask

  task automatic out_bit(string req, int line, logic exp);
    check(req, 64'(irq_out[line]), 64'(exp));
  endtask

  task automatic t_reset;
    logic [63:0] d;
    logic v;
    check("R1 out", 64'($countones(irq_out)), 0);
    rd_chk("R1 mask", 12'h020, 2'd3, '1);
    rd_chk("R1 ident", 12'h000, 2'd3, ID);
    rd_chk("R1 edge", 12'h040, 2'd3, 0);
    rd_chk("R1 vec", 12'h200, 2'd3, 0);
    rd(12'h100, 2'd3, d, v);
    check("R1 status", d, 0);
    check("R12 rsp_valid on read", 64'(v), 1);
    check("R12 ready", 64'(req_ready), 1);
    wr(12'h080, 2'd0, 0);
    check("R12 no rsp after write", 64'(rsp_valid), 0);
  endtask

  task automatic t_access;
    wr(12'h200, 2'd3, 64'h1716_1514_1312_1110);
    wr(12'h208, 2'd0, 64'h28);
    wr(12'h20C, 2'd2, 64'h2F2E_2D2C);
    rd_chk("R2 R10 vec word", 12'h208, 2'd3, 64'h2F2E_2D2C_0000_0028);
    rd_chk("R2 two-byte read", 12'h20C, 2'd1, 64'h2D2C);
    rd_chk("R2 one-byte read", 12'h201, 2'd0, 64'h11);
    wr(12'h308, 2'd3, 64'hDEAD_BEEF_0102_0304);
    rd_chk("R10 route", 12'h30C, 2'd2, 64'hDEAD_BEEF);
    wr(12'h0E3, 2'd0, 64'hA5);
    rd_chk("R10 R2 polarity", 12'h0E0, 2'd3, 64'hA500_0000);
    wr(12'h080, 2'd1, 64'hBEEF);
    rd_chk("R10 msgen", 12'h080, 2'd3, 64'hBEEF);
  endtask

  task automatic t_unmapped;
    wr(12'h0A0, 2'd3, '1);
    rd_chk("R9 auto0", 12'h0A0, 2'd3, 0);
    wr(12'h0C4, 2'd2, '1);
    rd_chk("R9 auto1", 12'h0C0, 2'd3, 0);
    wr(12'h3F8, 2'd3, '1);
    rd_chk("R9 unmapped", 12'h3F8, 2'd3, 0);
    wr(12'h000, 2'd3, 0);
    rd_chk("R9 ident ro", 12'h000, 2'd3, ID);
    rd_chk("R9 mask untouched", 12'h020, 2'd3, '1);
  endtask

  task automatic t_level;
    set_mask(~64'h4);
    set_in(64'h4);
    out_bit("R3 level rise", 'h12, 1);
    check("R3 single line", 64'($countones(irq_out)), 1);
    rd_chk("R3 R8 status", 12'h100, 2'd3, 64'h4);
    set_in(0);
    out_bit("R3 level fall", 'h12, 0);
    rd_chk("R3 status clear", 12'h100, 2'd3, 0);
  endtask

  task automatic t_edge_clear;
    wr(12'h040, 2'd3, 64'h8);
    set_in(64'h8);
    check("R4 masked pulse", 64'($countones(irq_out)), 0);
    set_in(0);
    set_mask(~64'hC);
    out_bit("R4 R7 pending kept", 'h13, 1);
    rd_chk("R4 status", 12'h100, 2'd3, 64'h8);
    repeat (3) @(negedge clk);
    out_bit("R4 R13 holds", 'h13, 1);
    wr(12'h060, 2'd0, 64'h08);
    out_bit("R6 clear edge", 'h13, 0);
    rd_chk("R6 status", 12'h100, 2'd3, 0);
    set_in(64'h4);
    out_bit("R6 level setup", 'h12, 1);
    wr(12'h060, 2'd0, 64'h04);
    out_bit("R6 level unaffected", 'h12, 1);
    rd_chk("R6 level status", 12'h100, 2'd3, 64'h4);
    set_in(0);
    out_bit("R3 fall after clear", 'h12, 0);
  endtask

  task automatic t_lowest;
    set_mask(~64'h50);
    set_in(64'h50);
    out_bit("R5 lowest served", 'h14, 1);
    out_bit("R5 higher waits", 'h16, 0);
    rd_chk("R5 status", 12'h100, 2'd3, 64'h10);
    set_in(0);
    check("R5 all low", 64'($countones(irq_out)), 0);
  endtask

  task automatic t_mask_down;
    set_mask(~64'h24);
    set_in(64'h04);
    set_in(64'h24);
    out_bit("R3 src2", 'h12, 1);
    out_bit("R3 src5", 'h15, 1);
    set_in(0);
    out_bit("R5 fall lowest", 'h12, 0);
    out_bit("R5 fall higher kept", 'h15, 1);
    rd_chk("R8 status residue", 12'h100, 2'd3, 64'h20);
    set_mask(~64'h04);
    out_bit("R7 mask down", 'h15, 0);
    rd_chk("R7 status", 12'h100, 2'd3, 0);
  endtask

  task automatic t_status_mask;
    set_in(64'h4);
    out_bit("R3 src2 again", 'h12, 1);
    set_mask('1);
    out_bit("R7 pending not dropped", 'h12, 1);
    rd_chk("R8 masked status", 12'h100, 2'd3, 0);
    set_mask(~64'h4);
    rd_chk("R8 unmasked status", 12'h100, 2'd3, 64'h4);
    set_in(0);
    out_bit("R3 drop", 'h12, 0);
  endtask

  task automatic t_order;
    wr(12'h040, 2'd3, 64'h1000);
    set_mask(~64'h1000);
    wr_in(12'h060, 2'd1, 64'h1000, 64'h1000);
    out_bit("R11 input then clear", 'h2C, 0);
    rd_chk("R11 status", 12'h100, 2'd3, 0);
    set_mask('1);
    set_mask(~64'h1000);
    out_bit("R11 pending gone", 'h2C, 0);
    set_in(0);
    set_in(64'h1000);
    out_bit("R4 edge delivers", 'h2C, 1);
    wr(12'h060, 2'd3, 64'h1000);
    out_bit("R6 clear", 'h2C, 0);
    set_in(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_access();
    t_unmapped();
    t_level();
    t_edge_clear();
    t_lowest();
    t_mask_down();
    t_status_mask();
    t_order();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule